// File: doc/BRIEF.md
# Address-Only Bus Write Latch

This block gives a host processor a way to store bytes into cartridge RAM over a bus that carries only addresses and has no write strobe. A valid bus cycle whose address falls in a 256-byte trigger window picks the data byte, which is the low byte of that address. The block then counts valid bus cycles. On the last cycle of the count it writes the byte to whatever address the bus carries on that cycle.

Any valid cycle counts, whether the processor is fetching an opcode, an operand or data. While a write is pending, further window accesses are ignored, so the first trigger wins. The write goes out as a one-cycle RAM write enable, together with the current bus address and the captured byte. The enable is gated by a write-permission input. When permission is low, the count still runs to its end and the pending state clears, but no enable is raised.

Top module: `addr_write_latch`

## Requirements
- R1: When no write is pending, a cycle with `bus_valid`=1 and `bus_addr[15:8]` equal to `WIN_HI` (default 8'hF0) arms a pending write. A cycle with `bus_valid`=0 arms nothing.
- R2: The pending write data is `bus_addr[7:0]` of the arming cycle. For example, an arming access at 16'hF000 gives data 8'h00.
- R3: The write fires on the DELAY-th valid cycle (default 5), counting the arming cycle as the first. Cycles with `bus_valid`=0 do not advance the count.
- R4: On the write cycle, `ram_waddr` equals that cycle's `bus_addr`, not the arming address.
- R5: While a write is pending, a window access changes neither the data nor the count.
- R6: `ram_we` is high for exactly one cycle, and the pending state clears on that cycle. A window address on the write cycle does not arm; a window access on the following valid cycle does.
- R7: When `wr_allow`=0 on the write cycle, `ram_we` stays low, yet the pending write still ends.
- R8: Synchronous active-high `rst` clears the pending flag, the count and the data. Afterwards, no write occurs until a new arming access.
- R9: `ram_we` is high only in a cycle with `bus_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Marks a real bus cycle |
| bus_addr | input | 16 | Address of the current bus cycle |
| wr_allow | input | 1 | Permits the RAM write |
| ram_we | output | 1 | One-cycle RAM write enable |
| ram_waddr | output | 16 | RAM write address (current bus address) |
| ram_wdata | output | 8 | Captured write byte |

## Verification
A wrong count or pending flag shows up as `ram_we` rising one or more valid cycles early or late, or rising when it should not. Every write is compared against a cycle model, so the fault appears at the first write after it occurs. A corrupted data latch appears on `ram_wdata` in the write cycle of the affected trigger. A re-arm fault shows up when an extra write appears DELAY-1 valid cycles after a write cycle that carried a window address.

// File: rtl/awl_pkg.sv
package awl_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  hit;
        data_t low;
    } win_t;

    function automatic win_t decode_window(input addr_t a, input logic [ADDR_W-DATA_W-1:0] hi);
        win_t w;
        w.hit = (a[ADDR_W-1:DATA_W] == hi);
        w.low = a[DATA_W-1:0];
        return w;
    endfunction
endpackage

// File: rtl/awl_window_decode.sv
module awl_window_decode
    import awl_pkg::*;
#(
    parameter logic [ADDR_W-DATA_W-1:0] WIN_HI = 8'hF0
) (
    input  addr_t addr,
    output win_t  win
);
    always_comb win = decode_window(addr, WIN_HI);
endmodule

// File: rtl/awl_delay_counter.sv
module awl_delay_counter #(
    parameter int DELAY = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic arm,
    output logic busy,
    output logic fire
);
    localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign busy = busy_q;
    assign fire = busy_q && step && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (fire) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (arm) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(1);
        end else if (busy_q && step) begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    assert_idle_cnt_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> cnt_q == '0);
    assert_fire_clears_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !busy_q);
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !step) |=> ($stable(cnt_q) && busy_q));
endmodule

// File: rtl/awl_data_latch.sv
module awl_data_latch
    import awl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  data_t din,
    output data_t dout
);
    data_t val_q;
    assign dout = val_q;

    always_ff @(posedge clk) begin
        if (rst)       val_q <= '0;
        else if (load) val_q <= din;
    end

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> val_q == $past(din));
endmodule

// File: rtl/addr_write_latch.sv
module addr_write_latch
    import awl_pkg::*;
#(
    parameter int                       DELAY  = 5,
    parameter logic [ADDR_W-DATA_W-1:0] WIN_HI = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_allow,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata
);
    win_t  win;
    logic  busy, fire, arm;
    data_t val;

    awl_window_decode #(.WIN_HI(WIN_HI)) u_dec (
        .addr (bus_addr),
        .win  (win)
    );

    assign arm = bus_valid && win.hit && !busy;

    awl_delay_counter #(.DELAY(DELAY)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .step (bus_valid),
        .arm  (arm),
        .busy (busy),
        .fire (fire)
    );

    awl_data_latch u_lat (
        .clk  (clk),
        .rst  (rst),
        .load (arm),
        .din  (win.low),
        .dout (val)
    );

    assign ram_we    = fire && wr_allow;
    assign ram_waddr = bus_addr;
    assign ram_wdata = val;

    assert_we_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> bus_valid);
    assert_we_needs_allow_R7: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> wr_allow);
    assert_we_single_R6: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);
    assert_value_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire) |=> $stable(ram_wdata));
endmodule

// File: tb/addr_write_latch_tb.sv
module addr_write_latch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY = 5;

    logic        clk = 0;
    logic        rst;
    logic        bus_valid;
    logic [15:0] bus_addr;
    logic        wr_allow;
    logic        ram_we;
    logic [15:0] ram_waddr;
    logic [7:0]  ram_wdata;

    int checks = 0;
    int errors = 0;
    int writes_seen = 0;

    logic       m_pend;
    int         m_cnt;
    logic [7:0] m_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_write_latch #(.DELAY(DELAY)) u_dut (
        .clk, .rst, .bus_valid, .bus_addr, .wr_allow,
        .ram_we, .ram_waddr, .ram_wdata
    );

    function automatic logic in_win(input logic [15:0] a);
        return a[15:8] == 8'hF0;
    endfunction

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [15:0] a, input logic al);
        logic fire;
        @(negedge clk);
        rst = r; bus_valid = v; bus_addr = a; wr_allow = al;
        #1;
        fire = !r && m_pend && v && (m_cnt == DELAY-1);
        if (!r) begin
            // R3 R7 R9: enable only on the counted write cycle with permission
            check(ram_we == (fire && al), "R3/R7/R9 ram_we", 16'(ram_we), 16'(fire && al));
            if (fire && al) begin
                writes_seen++;
                check(ram_waddr == a, "R4 ram_waddr", ram_waddr, a);
                check(ram_wdata == m_val, "R2 ram_wdata", 16'(ram_wdata), 16'(m_val));
            end
        end
        if (r) begin m_pend = 0; m_cnt = 0; m_val = 0; end
        else if (fire) begin m_pend = 0; m_cnt = 0; end
        else if (m_pend && v) m_cnt++;
        else if (!m_pend && v && in_win(a)) begin m_pend = 1; m_cnt = 1; m_val = a[7:0]; end
    endtask

    task automatic expect_we(input logic exp, input string req);
        check(ram_we == exp, req, 16'(ram_we), 16'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_pend = 0; m_cnt = 0; m_val = 0;
        rst = 1; bus_valid = 0; bus_addr = 0; wr_allow = 1;
        step(1, 0, 16'h0000, 1);
        step(1, 0, 16'h0000, 1);
        step(0, 0, 16'h1234, 1);
        expect_we(0, "R8 reset idle");

        // Directed: trigger at F000, window reads while pending, write at F004
        step(0, 1, 16'hF000, 1);   // R1 arm, R2 data 00
        step(0, 1, 16'hF03F, 1);   // R5 ignored
        step(0, 0, 16'hF077, 1);   // R3 invalid cycle not counted
        step(0, 1, 16'hF002, 1);
        step(0, 1, 16'h1000, 1);
        step(0, 1, 16'hF004, 1);   // write cycle, R6 no re-arm
        expect_we(1, "R3 write on 5th valid cycle");
        check(ram_wdata == 8'h00, "R2 data F000", 16'(ram_wdata), 16'h0000);
        check(ram_waddr == 16'hF004, "R4 addr", ram_waddr, 16'hF004);
        step(0, 1, 16'h2000, 1);
        expect_we(0, "R6 single pulse");
        for (int i = 0; i < 6; i++) step(0, 1, 16'h3000 + 16'(i), 1);
        expect_we(0, "R6 write cycle did not re-arm");

        // Back-to-back: window access right after write cycle re-arms
        step(0, 1, 16'hF0A5, 1);
        for (int i = 0; i < 3; i++) step(0, 1, 16'h4000, 1);
        step(0, 1, 16'hF0FF, 1);
        check(ram_wdata == 8'hA5, "R2 data A5", 16'(ram_wdata), 16'h00A5);
        step(0, 1, 16'hF011, 1);   // R6 next cycle arms
        for (int i = 0; i < 3; i++) step(0, 1, 16'h5555, 1);
        step(0, 1, 16'h7777, 1);
        expect_we(1, "R6 re-arm after write");
        check(ram_wdata == 8'h11, "R6 data 11", 16'(ram_wdata), 16'h0011);

        // Permission low: no enable, pending still ends
        step(0, 1, 16'hF042, 1);
        for (int i = 0; i < 3; i++) step(0, 1, 16'h0100, 1);
        step(0, 1, 16'h0200, 0);
        expect_we(0, "R7 blocked write");
        for (int i = 0; i < 5; i++) step(0, 1, 16'h0300, 1);
        expect_we(0, "R7 pending cleared");

        // Reset mid-pending
        step(0, 1, 16'hF099, 1);
        step(0, 1, 16'h0400, 1);
        step(1, 1, 16'h0400, 1);
        for (int i = 0; i < 5; i++) step(0, 1, 16'h0500, 1);
        expect_we(0, "R8 reset cleared pending");

        // Constrained random
        void'($urandom(32'd20240517));
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            a = ($urandom_range(0, 1) == 1) ? {8'hF0, 8'($urandom)} : 16'($urandom);
            step(($urandom_range(0, 499) == 0), ($urandom_range(0, 9) < 8), a,
                 ($urandom_range(0, 9) != 0));
        end
        check(writes_seen > 50, "R3 random writes occurred", 16'(writes_seen), 16'd51);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule